// File: doc/BRIEF.md
# Transmit/Receive Mailbox FIFO Pair

This block sits between a CPU register port and the frame side of a CAN controller. It holds two small frame queues: one carries frames from the CPU towards the bus, and one carries frames from the bus back to the CPU. Each queue entry holds a 32-bit identifier word, a 4-bit data length code and eight data bytes.

On the transmit side the CPU writes the identifier, length and data into a staging mailbox window. It then writes the commit code 0xFF to a separate advance register. Only that write enqueues the staged frame, and ordinary data writes never move a pointer. The receive side works the other way round. The CPU reads the head frame through a read window and releases it by writing 0xFF to the receive advance register. The bus side offers the oldest transmit entry with a valid/acknowledge pair and delivers received frames with a valid/ready pair.

Two control registers carry the enable bits, the number of unsent transmit entries and a receive-empty flag. A flag register records an advance on a full transmit queue or on an empty receive queue. Two interrupt lines report transmit completions and pending receive frames.

Top module: `mbx_fifo_pair`

Register word addresses on `reg_waddr_i` and `reg_raddr_i`:

| Address | Access | Contents |
|---|---|---|
| 0x0 | rw | transmit staging identifier word |
| 0x1 | rw | transmit staging length code, bits 3:0 |
| 0x2 | rw | transmit staging data bytes 0 to 3 |
| 0x3 | rw | transmit staging data bytes 4 to 7 |
| 0x4 | rw/ro | transmit control |
| 0x5 | wo | transmit advance; reads 0 |
| 0x8 | ro | receive head identifier word |
| 0x9 | ro | receive head length register |
| 0xA | ro | receive head data bytes 0 to 3 |
| 0xB | ro | receive head data bytes 4 to 7 |
| 0xC | rw/ro | receive control |
| 0xD | wo | receive advance; reads 0 |
| 0xE | ro | receive head normalized identifier |
| 0xF | w1c | error flags |

In the data words, data byte i sits at bits 8i+7:8i of the 64-bit data value.

## Requirements
- R1: After reset both queues are empty and both enables are 0. Transmit control (0x4) reads 0, receive control (0xC) reads 0x80, the flag register (0xF) reads 0, and `tx_done_irq_o`, `rx_irq_o`, `bus_tx_valid_o` and `bus_rx_ready_o` are all low.
- R2: A write of 0xFF in bits 7:0 to address 0x5, with transmit enabled (0x4 bit 0 = 1) and fewer than DEPTH entries queued, appends the staged frame. The unsent count in 0x4 bits 3:1 reads one higher from the next cycle on. A write of any other value to 0x5 changes nothing.
- R3: `bus_tx_valid_o` is high exactly when transmit is enabled and the unsent count is nonzero. The bus outputs then present the oldest queued frame, and a cycle with `bus_tx_ack_i` high removes that frame, so frames leave in commit order.
- R4: A transmit advance write while the queue holds DEPTH entries leaves the queue unchanged and sets flag bit 0 in 0xF.
- R5: `bus_rx_ready_o` is high exactly when receive is enabled and the receive queue holds fewer than DEPTH entries. A bus frame is stored only in a cycle with both valid and ready high. Bit 7 of 0xC reads 1 while the receive queue is empty, and `rx_irq_o` is high while receive is enabled and the queue is not empty.
- R6: A write of 0xFF to address 0xD, with receive enabled and a frame queued, releases the head frame. On an empty queue the write changes nothing and sets flag bit 1 in 0xF. Reads of 0x8 to 0xB and 0xE return 0 while the queue is empty.
- R7: Register 0x9 reports the raw length code in bits 3:0 and the usable byte count, min(code, 8), in bits 11:8. Data bytes at or above that count read as 0 in 0xA and 0xB.
- R8: Register 0xE copies identifier bits 31 (extended flag) and 30 (remote flag) and reads 0 in bit 29. With bit 31 set, bits 28:0 are the 29-bit extended identifier. With bit 31 clear, the 11-bit standard identifier held in bits 28:18 is returned in bits 10:0, with bits 28:11 at 0.
- R9: `tx_done_irq_o` is high for one cycle, in the cycle after each cycle in which a transmit entry is removed by the bus.
- R10: While an enable bit is 0 the corresponding queue is emptied and held empty. Advance writes to that queue are ignored and set no flag.
- R11: Writing 1 to a bit of 0xF clears that flag. A flag set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_waddr_i | input | 4 | register write word address |
| reg_wdata_i | input | 32 | register write data |
| reg_raddr_i | input | 4 | register read word address |
| reg_rdata_o | output | 32 | register read data, combinational from the address |
| bus_tx_valid_o | output | 1 | oldest transmit frame is offered |
| bus_tx_id_o | output | 32 | offered frame identifier word |
| bus_tx_dlc_o | output | 4 | offered frame length code |
| bus_tx_data_o | output | 64 | offered frame data bytes |
| bus_tx_ack_i | input | 1 | bus consumed the offered frame |
| bus_rx_valid_i | input | 1 | bus presents a received frame |
| bus_rx_id_i | input | 32 | received identifier word |
| bus_rx_dlc_i | input | 4 | received length code |
| bus_rx_data_i | input | 64 | received data bytes |
| bus_rx_ready_o | output | 1 | receive queue can accept a frame |
| tx_done_irq_o | output | 1 | one-cycle pulse per consumed transmit frame |
| rx_irq_o | output | 1 | receive frames pending |

## Verification
Register writes, advance writes and bus handshakes are captured on one rising edge. Their effect on counts, flags, `bus_tx_valid_o`, `bus_rx_ready_o` and `rx_irq_o` is due right after that edge. Read data is combinational from `reg_raddr_i` and the current state, so a read is due in the same cycle. The completion pulse is registered: it is due in the cycle after the acknowledging edge and must be gone one cycle later. A disable write needs a second edge before the counts read 0. The bench drives on falling edges and samples on the next falling edge, or 1 ns after setting a read address. This places each check exactly in the cycle the result is due.

// File: rtl/mbx_fifo_pkg.sv
package mbx_fifo_pkg;
  localparam int ID_W      = 32;
  localparam int DLC_W     = 4;
  localparam int DATA_W    = 64;
  localparam int MAX_BYTES = DATA_W / 8;
  localparam int AW        = 4;
  localparam logic [7:0] KICK_CODE = 8'hFF;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } mbx_frame_t;

  typedef enum logic [AW-1:0] {
    A_TX_ID   = 4'h0,
    A_TX_DLC  = 4'h1,
    A_TX_DLO  = 4'h2,
    A_TX_DHI  = 4'h3,
    A_TX_CTL  = 4'h4,
    A_TX_KICK = 4'h5,
    A_RX_ID   = 4'h8,
    A_RX_DLC  = 4'h9,
    A_RX_DLO  = 4'hA,
    A_RX_DHI  = 4'hB,
    A_RX_CTL  = 4'hC,
    A_RX_KICK = 4'hD,
    A_RX_IDN  = 4'hE,
    A_FLAGS   = 4'hF
  } mbx_addr_e;
endpackage

// File: rtl/mbx_frame_fifo.sv
module mbx_frame_fifo
  import mbx_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  mbx_frame_t       din_i,
  input  logic             pop_i,
  output mbx_frame_t       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  mbx_frame_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count == CNT_W'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign count_o = count;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr] <= din_i;
  end

  // R4: occupancy never exceeds the depth
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));

  // R2: an accepted push alone raises the count by exactly one
  a_r2_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i && !flush_i) |=> (count == $past(count) + 1'b1));

  // R6: a pop request on an empty queue leaves it empty
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/mbx_ctrl_regs.sv
module mbx_ctrl_regs
  import mbx_fifo_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic          tx_full_i,
  input  logic          rx_empty_i,
  output mbx_frame_t    tx_stage_o,
  output logic          tx_en_o,
  output logic          rx_en_o,
  output logic          tx_push_o,
  output logic          rx_pop_o,
  output logic [1:0]    flags_o
);
  mbx_frame_t stage;
  logic       tx_en, rx_en;
  logic [1:0] flags, flag_set, flag_clr;
  logic       tx_kick, rx_kick;

  assign tx_kick = we_i && (waddr_i == A_TX_KICK) && (wdata_i[7:0] == KICK_CODE);
  assign rx_kick = we_i && (waddr_i == A_RX_KICK) && (wdata_i[7:0] == KICK_CODE);

  assign tx_push_o = tx_kick && tx_en && !tx_full_i;
  assign rx_pop_o  = rx_kick && rx_en && !rx_empty_i;

  assign flag_set = {rx_kick && rx_en && rx_empty_i, tx_kick && tx_en && tx_full_i};
  assign flag_clr = (we_i && waddr_i == A_FLAGS) ? wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage <= '0;
      tx_en <= 1'b0;
      rx_en <= 1'b0;
      flags <= '0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      if (we_i) begin
        case (waddr_i)
          A_TX_ID:  stage.id          <= wdata_i;
          A_TX_DLC: stage.dlc         <= wdata_i[DLC_W-1:0];
          A_TX_DLO: stage.data[31:0]  <= wdata_i;
          A_TX_DHI: stage.data[63:32] <= wdata_i;
          A_TX_CTL: tx_en             <= wdata_i[0];
          A_RX_CTL: rx_en             <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  assign tx_stage_o = stage;
  assign tx_en_o    = tx_en;
  assign rx_en_o    = rx_en;
  assign flags_o    = flags;

  // R4: an advance on a full, enabled transmit queue raises the overflow flag
  a_r4_ovf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_kick && tx_en && tx_full_i) |=> flags[0]);

  // R6: an advance on an empty, enabled receive queue raises the underflow flag
  a_r6_unf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_kick && rx_en && rx_empty_i) |=> flags[1]);

  // R11: a flag with no set and no write stays where it was
  a_r11_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i) |=> (flags_o == $past(flags_o)));
endmodule

// File: rtl/mbx_rx_view.sv
module mbx_rx_view
  import mbx_fifo_pkg::*;
(
  input  mbx_frame_t  head_i,
  output logic [31:0] dlc_reg_o,
  output logic [63:0] data_o,
  output logic [31:0] idn_o
);
  logic [3:0] len;
  logic       ide;

  assign len = (head_i.dlc > 4'(MAX_BYTES)) ? 4'(MAX_BYTES) : head_i.dlc;
  assign dlc_reg_o = {20'b0, len, 4'b0, head_i.dlc};

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    assign data_o[b*8 +: 8] = (4'(b) < len) ? head_i.data[b*8 +: 8] : 8'h00;
  end

  assign ide   = head_i.id[31];
  assign idn_o = {head_i.id[31:30], 1'b0,
                  ide ? head_i.id[28:0] : {18'b0, head_i.id[28:18]}};
endmodule

// File: rtl/mbx_fifo_pair.sv
module mbx_fifo_pair
  import mbx_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_waddr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic [3:0]    reg_raddr_i,
  output logic [31:0]   reg_rdata_o,
  output logic          bus_tx_valid_o,
  output logic [31:0]   bus_tx_id_o,
  output logic [3:0]    bus_tx_dlc_o,
  output logic [63:0]   bus_tx_data_o,
  input  logic          bus_tx_ack_i,
  input  logic          bus_rx_valid_i,
  input  logic [31:0]   bus_rx_id_i,
  input  logic [3:0]    bus_rx_dlc_i,
  input  logic [63:0]   bus_rx_data_i,
  output logic          bus_rx_ready_o,
  output logic          tx_done_irq_o,
  output logic          rx_irq_o
);
  mbx_frame_t       tx_stage, tx_head, rx_in, rx_head_raw, rx_head;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_en, rx_en, tx_push, tx_pop, rx_push, rx_pop;
  logic [1:0]       flags;
  logic [2:0]       unsent;
  logic [31:0]      rx_dlc_reg, rx_idn;
  logic [63:0]      rx_data_m;
  logic             done_q;

  mbx_ctrl_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .waddr_i(reg_waddr_i), .wdata_i(reg_wdata_i),
    .tx_full_i(tx_full), .rx_empty_i(rx_empty),
    .tx_stage_o(tx_stage), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .tx_push_o(tx_push), .rx_pop_o(rx_pop), .flags_o(flags)
  );

  mbx_frame_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(!tx_en),
    .push_i(tx_push), .din_i(tx_stage), .pop_i(tx_pop),
    .head_o(tx_head), .count_o(tx_count), .full_o(tx_full), .empty_o(tx_empty)
  );

  assign rx_in   = {bus_rx_id_i, bus_rx_dlc_i, bus_rx_data_i};
  assign rx_push = bus_rx_valid_i && bus_rx_ready_o;

  mbx_frame_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(!rx_en),
    .push_i(rx_push), .din_i(rx_in), .pop_i(rx_pop),
    .head_o(rx_head_raw), .count_o(rx_count), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign rx_head = rx_empty ? '0 : rx_head_raw;

  mbx_rx_view u_view (
    .head_i(rx_head), .dlc_reg_o(rx_dlc_reg), .data_o(rx_data_m), .idn_o(rx_idn)
  );

  // bus side
  assign bus_tx_valid_o = tx_en && !tx_empty;
  assign bus_tx_id_o    = bus_tx_valid_o ? tx_head.id   : '0;
  assign bus_tx_dlc_o   = bus_tx_valid_o ? tx_head.dlc  : '0;
  assign bus_tx_data_o  = bus_tx_valid_o ? tx_head.data : '0;
  assign tx_pop         = bus_tx_valid_o && bus_tx_ack_i;
  assign bus_rx_ready_o = rx_en && !rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= tx_pop;
  end

  assign tx_done_irq_o = done_q;
  assign rx_irq_o      = rx_en && !rx_empty;
  assign unsent        = 3'(tx_count);

  always_comb begin
    case (reg_raddr_i)
      A_TX_ID:  reg_rdata_o = tx_stage.id;
      A_TX_DLC: reg_rdata_o = {28'b0, tx_stage.dlc};
      A_TX_DLO: reg_rdata_o = tx_stage.data[31:0];
      A_TX_DHI: reg_rdata_o = tx_stage.data[63:32];
      A_TX_CTL: reg_rdata_o = {28'b0, unsent, tx_en};
      A_RX_ID:  reg_rdata_o = rx_head.id;
      A_RX_DLC: reg_rdata_o = rx_dlc_reg;
      A_RX_DLO: reg_rdata_o = rx_data_m[31:0];
      A_RX_DHI: reg_rdata_o = rx_data_m[63:32];
      A_RX_CTL: reg_rdata_o = {24'b0, rx_empty, 6'b0, rx_en};
      A_RX_IDN: reg_rdata_o = rx_idn;
      A_FLAGS:  reg_rdata_o = {30'b0, flags};
      default:  reg_rdata_o = '0;
    endcase
  end

  // R3: frames are offered only while transmit is enabled
  a_r3_valid_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_tx_valid_o |-> tx_en);

  // R9: every completion pulse follows an acknowledged offer
  a_r9_done_follows_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_irq_o |-> $past(bus_tx_valid_o && bus_tx_ack_i));

  // R5: ready is never given to a full receive queue
  a_r5_ready_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rx_ready_o |-> (rx_count < CNT_W'(DEPTH)));

  // R10: a disabled queue is empty one cycle later
  a_r10_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en && !reg_we_i) |=> (tx_count == '0));
endmodule

// File: tb/mbx_fifo_pair_tb_top.sv
module mbx_fifo_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_valid, tx_ack = 1'b0;
  logic [31:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        done_irq, rx_irq;

  int n_cmp = 0, n_fail = 0;
  bit finished = 0;

  // model state
  logic [31:0] mtx_id [DEPTH];
  logic [3:0]  mtx_dlc [DEPTH];
  logic [63:0] mtx_dat [DEPTH];
  int          tx_h = 0, tx_c = 0;
  logic [31:0] mrx_id [DEPTH];
  logic [3:0]  mrx_dlc [DEPTH];
  logic [63:0] mrx_dat [DEPTH];
  int          rx_h = 0, rx_c = 0;
  bit          ten = 0, ren = 0;
  logic [1:0]  mflags = '0;

  mbx_fifo_pair #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .bus_tx_valid_o(tx_valid), .bus_tx_id_o(tx_id), .bus_tx_dlc_o(tx_dlc),
    .bus_tx_data_o(tx_data), .bus_tx_ack_i(tx_ack),
    .bus_rx_valid_i(rx_valid), .bus_rx_id_i(rx_id), .bus_rx_dlc_i(rx_dlc),
    .bus_rx_data_i(rx_data), .bus_rx_ready_o(rx_ready),
    .tx_done_irq_o(done_irq), .rx_irq_o(rx_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [3:0] f_len(input logic [3:0] d);
    return (d > 4'd8) ? 4'd8 : d;
  endfunction

  function automatic logic [63:0] f_mask(input logic [63:0] d, input logic [3:0] c);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (i < int'(f_len(c))) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] f_norm(input logic [31:0] id);
    if (id[31]) return {id[31:30], 1'b0, id[28:0]};
    return {id[31:30], 19'b0, id[28:18]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    raddr = a; #1; v = rdata;
  endtask

  task automatic tx_send(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] d);
    logic [31:0] v;
    wr(4'h0, id); wr(4'h1, {28'b0, dlc}); wr(4'h2, d[31:0]); wr(4'h3, d[63:32]);
    wr(4'h5, 32'hFF);
    if (ten) begin
      if (tx_c < DEPTH) begin
        mtx_id[(tx_h + tx_c) % DEPTH] = id;
        mtx_dlc[(tx_h + tx_c) % DEPTH] = dlc;
        mtx_dat[(tx_h + tx_c) % DEPTH] = d;
        tx_c++;
      end else mflags[0] = 1'b1;
    end
    rd(4'h4, v);
    chk("R2 unsent count after advance", v, {28'b0, 3'(tx_c), ten});
  endtask

  task automatic bus_ack();
    if (tx_c > 0) begin
      chk("R3 tx valid", tx_valid, 1);
      chk("R3 tx id order", tx_id, mtx_id[tx_h]);
      chk("R3 tx dlc", tx_dlc, mtx_dlc[tx_h]);
      chk("R3 tx data", tx_data, mtx_dat[tx_h]);
      tx_ack = 1'b1;
      @(negedge clk); tx_ack = 1'b0;
      tx_h = (tx_h + 1) % DEPTH; tx_c--;
      chk("R9 done pulse high", done_irq, 1);
      @(negedge clk);
      chk("R9 done pulse ends", done_irq, 0);
    end else begin
      chk("R3 tx valid low when none queued", tx_valid, 0);
    end
  endtask

  task automatic rx_bus(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] d);
    bit exp_rdy;
    rx_valid = 1'b1; rx_id = id; rx_dlc = dlc; rx_data = d;
    #1;
    exp_rdy = ren && (rx_c < DEPTH);
    chk("R5 rx ready", rx_ready, exp_rdy);
    @(negedge clk); rx_valid = 1'b0;
    if (exp_rdy) begin
      mrx_id[(rx_h + rx_c) % DEPTH] = id;
      mrx_dlc[(rx_h + rx_c) % DEPTH] = dlc;
      mrx_dat[(rx_h + rx_c) % DEPTH] = d;
      rx_c++;
    end
    #1;
    chk("R5 rx irq level", rx_irq, ren && (rx_c > 0));
  endtask

  task automatic rx_take();
    logic [31:0] v, eid;
    logic [3:0]  edl;
    logic [63:0] edt;
    eid = (rx_c > 0) ? mrx_id[rx_h] : '0;
    edl = (rx_c > 0) ? mrx_dlc[rx_h] : '0;
    edt = (rx_c > 0) ? f_mask(mrx_dat[rx_h], edl) : '0;
    rd(4'h8, v); chk("R6 rx head id", v, eid);
    rd(4'h9, v); chk("R7 rx length register", v, {20'b0, f_len(edl), 4'b0, edl});
    rd(4'hA, v); chk("R7 rx data low masked", v, edt[31:0]);
    rd(4'hB, v); chk("R7 rx data high masked", v, edt[63:32]);
    rd(4'hE, v); chk("R8 normalized id", v, (rx_c > 0) ? f_norm(eid) : 32'h0);
    wr(4'hD, 32'hFF);
    if (ren) begin
      if (rx_c > 0) begin rx_h = (rx_h + 1) % DEPTH; rx_c--; end
      else mflags[1] = 1'b1;
    end
    rd(4'hC, v);
    chk("R5 rx empty flag", v, {24'b0, rx_c == 0, 6'b0, ren});
  endtask

  task automatic chk_flags(input string req);
    logic [31:0] v;
    rd(4'hF, v); chk(req, v, {30'b0, mflags});
    wr(4'hF, 32'h3); mflags = '0;
    rd(4'hF, v); chk("R11 flags cleared", v, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h4, v); chk("R1 tx control", v, 0);
    rd(4'hC, v); chk("R1 rx control", v, 32'h80);
    rd(4'hF, v); chk("R1 flags", v, 0);
    chk("R1 irqs and handshakes", {done_irq, rx_irq, tx_valid, rx_ready}, 0);

    // R10 advances while disabled are ignored, no flag
    tx_send(32'h1234, 4'd2, 64'h55);
    rx_take();
    chk_flags("R10 no flag while disabled");

    wr(4'h4, 1); ten = 1;
    wr(4'hC, 1); ren = 1;

    // R2 non-commit value does nothing
    wr(4'h5, 32'h7F);
    rd(4'h4, v); chk("R2 non-0xFF advance ignored", v, 32'h1);

    // R4 fill and overflow
    for (int i = 0; i < DEPTH + 1; i++)
      tx_send(32'h8000_0000 | i, 4'(i + 6), {$urandom, $urandom});
    chk_flags("R4 overflow flag");
    for (int i = 0; i < DEPTH + 1; i++) bus_ack();

    // R6 underflow on empty receive queue
    rx_take();
    chk_flags("R6 underflow flag");

    // R7/R8 corner frames, and R5 refusal when full
    rx_bus(32'h8ABC_DEF1, 4'd15, 64'h1122_3344_5566_7788);
    rx_bus(32'h4FFC_0000 | 32'h3FFFF, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rx_bus(32'h0004_0000, 4'd0, 64'hDEAD_BEEF_0000_0001);
    rx_bus(32'hC000_0001, 4'd8, 64'hA5A5_5A5A_0F0F_F0F0);
    rx_bus(32'h1, 4'd1, 64'h1);
    for (int i = 0; i < DEPTH + 1; i++) rx_take();
    chk_flags("R6 flag after drain");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0, 1: tx_send($urandom, 4'($urandom), {$urandom, $urandom});
        2:    bus_ack();
        3:    rx_bus($urandom, 4'($urandom), {$urandom, $urandom});
        4:    rx_take();
        default: chk_flags("R4 R6 random flags");
      endcase
    end

    // R10 disable flushes
    tx_send(32'h77, 4'd1, 64'h9);
    rx_bus(32'h88, 4'd1, 64'h9);
    wr(4'h4, 0); ten = 0; tx_c = 0; tx_h = 0;
    wr(4'hC, 0); ren = 0; rx_c = 0; rx_h = 0;
    @(negedge clk);
    rd(4'h4, v); chk("R10 tx flushed", v, 0);
    rd(4'hC, v); chk("R10 rx flushed", v, 32'h80);
    chk("R10 handshakes idle", {tx_valid, rx_ready, rx_irq}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule